// File: doc/BRIEF.md
# Backplane-to-line channel mapper (transmit)

This block sits on the transmit side between a 2.048 Mb/s serial TDM backplane and a 192 kbit/s basic-rate line framer. After each backplane frame pulse it collects the first four 8-bit timeslots. Timeslot 0 carries the D channel, timeslot 1 the control channel (C), timeslot 2 B1 and timeslot 3 B2. From these it builds a line-half record of one B1 octet, one B2 octet and two D bits. The record is placed in either the first or the second 125 µs half of the 250 µs line frame.

A half selector decides which half a backplane frame goes into. At 1, the frame goes to the next second half, which is the second half of the line frame now in progress. At 0, it goes to the next first half, which is the start of the following line frame. The selector is held internally. It changes when the half pin, sampled at a frame pulse, differs from its previous sample. In network mode it can also be changed by a register write. Two data modes shape the record. In bypass, the two low D bits go straight to the line when both packet-formatter directions are disabled. In D-in-B1 mode, the whole D octet takes the place of B1.

The serial input is a valid-only stream and cannot be stalled: the backplane never waits. The line side is a valid/ready stream of half records. A record and its half flag are held unchanged while ready is low. The framer takes one record per line half, and halves alternate 0, 1, 0, 1. One pending slot per half gives double buffering, so a record that has already been handed out is never changed by a later capture.

Top module: `tdm_line_mapper`

## Requirements
- R1: While reset is asserted, ln_valid is 0. After reset, ln_valid goes to 1 and stays at 1. The first record offered has ln_half=0 and is idle (ln_b1=8'hFF, ln_b2=8'hFF, ln_d=2'b11). Every record stays idle until data from a frame pulse has been captured.
- R2: A serial bit with bp_vld=1 and bp_fp=1 starts a frame. The 32 bits that follow, the first one included, are taken MSB first as timeslots D, C, B1 and B2. Bits arriving after the 32nd bit and before the next frame pulse are ignored. A frame pulse in the middle of a frame restarts the capture. C is never sent to the line.
- R3: A frame whose half selector is 1 is sent in the next record that has ln_half=1.
- R4: A frame whose half selector is 0 is sent in the next record that has ln_half=0.
- R5: A record is accepted when ln_valid and ln_ready are both 1 at a clock edge. Each accept moves the output to the other half. While ln_ready is 0, ln_half, ln_b1, ln_b2 and ln_d hold their values.
- R6: Each captured frame is sent once. A half with no new capture is sent idle (all ones).
- R7: half_pin is sampled at each frame pulse and compared with its previous sample. The previous sample is 0 after reset. If the two differ, the selector takes the pin value. If they are equal, the selector keeps its internal value. The selector value after this update applies to the frame that pulse starts.
- R8: With term_mode=0, a cycle with cfg_half_wr=1 loads cfg_half into the selector. With term_mode=1, the write is ignored. If a pin change at a frame pulse falls in the same cycle as a write, the pin value wins.
- R9: When cfg_hdlc_tx_en and cfg_hdlc_rx_en are both 0, ln_d[1:0] equals bits [1:0] of the D timeslot. Otherwise ln_d is 2'b11.
- R10: With cfg_dinb=1, ln_b1 carries the D timeslot octet and ln_d is forced to 2'b11, whatever the bypass setting. ln_b2 still carries B2.
- R11: A later frame mapped to the same half replaces a pending record that has not yet been handed out. A capture that finishes in the same cycle its half is handed out stays pending for the next record of that half. The record handed out in that cycle keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bp_fp | input | 1 | Frame pulse, qualified by bp_vld, marks the first bit of a frame |
| bp_vld | input | 1 | Serial bit strobe (no back-pressure) |
| bp_bit | input | 1 | Serial backplane data, MSB first |
| term_mode | input | 1 | 1 = terminal mode (register writes to the half selector ignored) |
| half_pin | input | 1 | Half-select pin, sampled at frame pulses |
| cfg_half_wr | input | 1 | Register write strobe for the half selector |
| cfg_half | input | 1 | Value written to the half selector |
| cfg_dinb | input | 1 | D octet replaces B1 on the line |
| cfg_hdlc_tx_en | input | 1 | Packet-formatter transmit enable |
| cfg_hdlc_rx_en | input | 1 | Packet-formatter receive enable |
| ln_valid | output | 1 | Line record valid |
| ln_ready | input | 1 | Line framer takes the record |
| ln_half | output | 1 | 0 = first half, 1 = second half |
| ln_b1 | output | 8 | B1 octet of the record |
| ln_b2 | output | 8 | B2 octet of the record |
| ln_d | output | 2 | D bits of the record |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a capture writing into a half slot at the same edge the framer takes that half. The second pair is a half-pin change at a frame pulse together with a register write to the selector. The second pair is provoked directly, by pulsing the write on the frame-pulse bit while the pin flips; the pin value must win. The first pair is provoked by streaming frames back to back while ln_ready follows an irregular pattern, so capture completions drift across hand-offs. A behavioural model in the bench judges every cycle: the taken record must keep its old contents and the new capture must appear at the next record of that half.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int SLOT_W      = 8;
  localparam int NUM_TS      = 4;
  localparam int LINE_D_W    = 2;
  localparam int LINE_HALVES = 2;
  localparam int HALF_W      = $clog2(LINE_HALVES);

  localparam int TS_D  = 0;
  localparam int TS_C  = 1;
  localparam int TS_B1 = 2;
  localparam int TS_B2 = 3;

  typedef struct packed {
    logic [SLOT_W-1:0]   b1;
    logic [SLOT_W-1:0]   b2;
    logic [LINE_D_W-1:0] d;
  } half_rec_t;

  localparam half_rec_t IDLE_REC = '{b1: '1, b2: '1, d: '1};
endpackage

// File: rtl/tlm_capture.sv
module tlm_capture
  import tlm_pkg::*;
#(
  parameter int TS_W  = SLOT_W,
  parameter int N_TS  = NUM_TS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fp,
  input  logic                     vld,
  input  logic                     din,
  output logic                     done,
  output logic [N_TS-1:0][TS_W-1:0] ts
);
  localparam int FRAME_BITS = TS_W * N_TS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (vld) begin
        if (fp) begin
          sh_q     <= {{(FRAME_BITS-1){1'b0}}, din};
          cnt_q    <= CNT_W'(1);
          active_q <= 1'b1;
        end else if (active_q) begin
          sh_q  <= {sh_q[FRAME_BITS-2:0], din};
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
            active_q <= 1'b0;
            done     <= 1'b1;
          end
        end
      end
    end
  end

  // Timeslot k occupies the k-th octet counted from the frame's first bit.
  for (genvar k = 0; k < N_TS; k++) begin : g_ts
    assign ts[k] = sh_q[FRAME_BITS-1-k*TS_W -: TS_W];
  end
endmodule

// File: rtl/tlm_half_ctl.sv
module tlm_half_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_start,
  input  logic pin,
  input  logic term_mode,
  input  logic wr,
  input  logic wr_val,
  output logic half_eff,
  output logic frame_half
);
  logic pin_prev_q;
  logic pin_edge;
  logic half_nxt;

  always_comb begin
    pin_edge = fp_start && (pin != pin_prev_q);
    if (pin_edge)               half_nxt = pin;
    else if (wr && !term_mode)  half_nxt = wr_val;
    else                        half_nxt = half_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_eff   <= 1'b0;
      frame_half <= 1'b0;
      pin_prev_q <= 1'b0;
    end else begin
      half_eff <= half_nxt;
      if (fp_start) begin
        pin_prev_q <= pin;
        frame_half <= half_nxt;
      end
    end
  end
endmodule

// File: rtl/tlm_slot_buf.sv
module tlm_slot_buf
  import tlm_pkg::*;
#(
  parameter int N_HALF = LINE_HALVES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [HALF_W-1:0]          wr_half,
  input  logic [NUM_TS-1:0][SLOT_W-1:0] ts,
  input  logic                       cfg_dinb,
  input  logic                       cfg_tx_en,
  input  logic                       cfg_rx_en,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [HALF_W-1:0]          out_half,
  output half_rec_t                  out_rec
);
  half_rec_t             wr_rec;
  logic                  bypass;
  logic                  take;
  logic [HALF_W-1:0]     nxt_half;
  logic [N_HALF-1:0]     full;
  half_rec_t             data [N_HALF];

  always_comb begin
    bypass    = !cfg_tx_en && !cfg_rx_en;
    wr_rec.b2 = ts[TS_B2];
    if (cfg_dinb) begin
      wr_rec.b1 = ts[TS_D];
      wr_rec.d  = '1;
    end else begin
      wr_rec.b1 = ts[TS_B1];
      wr_rec.d  = bypass ? ts[TS_D][LINE_D_W-1:0] : '1;
    end
  end

  assign take     = out_valid && out_ready;
  assign nxt_half = out_half + HALF_W'(1);

  for (genvar h = 0; h < N_HALF; h++) begin : g_slot
    logic      full_q;
    half_rec_t data_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= IDLE_REC;
      end else begin
        if (take && nxt_half == HALF_W'(h)) full_q <= 1'b0;
        if (wr_en && wr_half == HALF_W'(h)) begin
          full_q <= 1'b1;
          data_q <= wr_rec;
        end
      end
    end
    assign full[h] = full_q;
    assign data[h] = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_half  <= '0;
      out_rec   <= IDLE_REC;
    end else begin
      out_valid <= 1'b1;
      if (take) begin
        out_half <= nxt_half;
        out_rec  <= full[nxt_half] ? data[nxt_half] : IDLE_REC;
      end
    end
  end
endmodule

// File: rtl/tdm_line_mapper.sv
module tdm_line_mapper
  import tlm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_fp,
  input  logic              bp_vld,
  input  logic              bp_bit,
  input  logic              term_mode,
  input  logic              half_pin,
  input  logic              cfg_half_wr,
  input  logic              cfg_half,
  input  logic              cfg_dinb,
  input  logic              cfg_hdlc_tx_en,
  input  logic              cfg_hdlc_rx_en,
  output logic              ln_valid,
  input  logic              ln_ready,
  output logic              ln_half,
  output logic [SLOT_W-1:0] ln_b1,
  output logic [SLOT_W-1:0] ln_b2,
  output logic [LINE_D_W-1:0] ln_d
);
  logic                         fp_start;
  logic                         cap_done;
  logic [NUM_TS-1:0][SLOT_W-1:0] ts;
  logic                         half_eff;
  logic                         frame_half;
  logic [HALF_W-1:0]            out_half;
  half_rec_t                    out_rec;

  assign fp_start = bp_fp && bp_vld;

  tlm_capture #(.TS_W(SLOT_W), .N_TS(NUM_TS)) i_capture (
    .clk  (clk),
    .rst_n(rst_n),
    .fp   (bp_fp),
    .vld  (bp_vld),
    .din  (bp_bit),
    .done (cap_done),
    .ts   (ts)
  );

  tlm_half_ctl i_half_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fp_start  (fp_start),
    .pin       (half_pin),
    .term_mode (term_mode),
    .wr        (cfg_half_wr),
    .wr_val    (cfg_half),
    .half_eff  (half_eff),
    .frame_half(frame_half)
  );

  tlm_slot_buf #(.N_HALF(LINE_HALVES)) i_slot_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cap_done),
    .wr_half  (HALF_W'(frame_half)),
    .ts       (ts),
    .cfg_dinb (cfg_dinb),
    .cfg_tx_en(cfg_hdlc_tx_en),
    .cfg_rx_en(cfg_hdlc_rx_en),
    .out_ready(ln_ready),
    .out_valid(ln_valid),
    .out_half (out_half),
    .out_rec  (out_rec)
  );

  assign ln_half = out_half[0];
  assign ln_b1   = out_rec.b1;
  assign ln_b2   = out_rec.b2;
  assign ln_d    = out_rec.d;
endmodule

// File: rtl/tlm_chk.sv
module tlm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bp_fp,
  input logic       bp_vld,
  input logic       term_mode,
  input logic       cfg_half_wr,
  input logic       ln_valid,
  input logic       ln_ready,
  input logic       ln_half,
  input logic [7:0] ln_b1,
  input logic [7:0] ln_b2,
  input logic [1:0] ln_d,
  input logic       half_eff,
  input logic       cap_done
);
  logic seen_fp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_fp_q <= 1'b0;
    else if (bp_fp && bp_vld) seen_fp_q <= 1'b1;
  end

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_valid && !ln_ready) |=> $stable({ln_half, ln_b1, ln_b2, ln_d}));

  p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_valid && ln_ready) |=> (ln_half != $past(ln_half)));

  p_valid_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ln_valid |=> ln_valid);

  p_idle_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fp_q |-> (ln_b1 == 8'hFF && ln_b2 == 8'hFF && ln_d == 2'b11));

  p_term_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (term_mode && cfg_half_wr && !(bp_fp && bp_vld)) |=> $stable(half_eff));

  p_done_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> !cap_done);
endmodule

bind tdm_line_mapper tlm_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bp_fp      (bp_fp),
  .bp_vld     (bp_vld),
  .term_mode  (term_mode),
  .cfg_half_wr(cfg_half_wr),
  .ln_valid   (ln_valid),
  .ln_ready   (ln_ready),
  .ln_half    (ln_half),
  .ln_b1      (ln_b1),
  .ln_b2      (ln_b2),
  .ln_d       (ln_d),
  .half_eff   (half_eff),
  .cap_done   (cap_done)
);

// File: tb/test_tdm_line_mapper.sv
`timescale 1ns/1ps
module test_tdm_line_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bp_fp = 1'b0, bp_vld = 1'b0, bp_bit = 1'b0;
  logic term_mode = 1'b0, half_pin = 1'b0;
  logic cfg_half_wr = 1'b0, cfg_half = 1'b0, cfg_dinb = 1'b0;
  logic cfg_hdlc_tx_en = 1'b1, cfg_hdlc_rx_en = 1'b1;
  logic ln_ready = 1'b0;
  logic ln_valid, ln_half;
  logic [7:0] ln_b1, ln_b2;
  logic [1:0] ln_d;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tdm_line_mapper i_tdm_line_mapper (.*);

  // ---------------- behavioural reference model ----------------
  bit       m_valid, m_half;
  bit [7:0] m_b1, m_b2;
  bit [1:0] m_d;
  bit       m_full [2];
  bit [17:0] m_slot [2];
  bit       m_active, m_pend, m_pend_half, m_fhalf, m_sel, m_pprev;
  int       m_cnt;
  bit [31:0] m_bits, m_pend_bits;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_half = 0; m_b1 = 8'hFF; m_b2 = 8'hFF; m_d = 2'b11;
      m_full[0] = 0; m_full[1] = 0; m_active = 0; m_pend = 0;
      m_fhalf = 0; m_sel = 0; m_pprev = 0; m_cnt = 0;
    end else begin
      bit nh, h;
      bit [7:0] d8, b1, b2;
      bit [1:0] dd;
      if (ln_ready && m_valid) begin
        nh = !m_half;
        if (m_full[nh]) {m_b1, m_b2, m_d} = m_slot[nh];
        else {m_b1, m_b2, m_d} = {8'hFF, 8'hFF, 2'b11};
        m_full[nh] = 0;
        m_half = nh;
      end
      m_valid = 1;
      if (m_pend) begin
        d8 = m_pend_bits[31:24]; b1 = m_pend_bits[15:8]; b2 = m_pend_bits[7:0];
        if (cfg_dinb) begin b1 = d8; dd = 2'b11; end
        else dd = (!cfg_hdlc_tx_en && !cfg_hdlc_rx_en) ? d8[1:0] : 2'b11;
        m_slot[m_pend_half] = {b1, b2, dd};
        m_full[m_pend_half] = 1;
        m_pend = 0;
      end
      h = m_sel;
      if (bp_fp && bp_vld && half_pin != m_pprev) h = half_pin;
      else if (cfg_half_wr && !term_mode) h = cfg_half;
      if (bp_fp && bp_vld) begin m_pprev = half_pin; m_fhalf = h; end
      m_sel = h;
      if (bp_vld) begin
        if (bp_fp) begin m_bits = {31'd0, bp_bit}; m_cnt = 1; m_active = 1; end
        else if (m_active) begin
          m_bits = {m_bits[30:0], bp_bit}; m_cnt++;
          if (m_cnt == 32) begin
            m_active = 0; m_pend = 1; m_pend_bits = m_bits; m_pend_half = m_fhalf;
          end
        end
      end
    end
  end

  // R5: the line stream is compared against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (ln_valid !== m_valid || (m_valid &&
          {ln_half, ln_b1, ln_b2, ln_d} !== {m_half, m_b1, m_b2, m_d})) begin
        bad++;
        $display("FAIL R5 model compare: actual=%b/%b %h %h %b expected=%b/%b %h %h %b",
                 ln_valid, ln_half, ln_b1, ln_b2, ln_d, m_valid, m_half, m_b1, m_b2, m_d);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_frame(input logic [7:0] d, c, b1, b2, input logic pin,
                            input logic wr_now, input logic wr_v);
    logic [31:0] w;
    w = {d, c, b1, b2};
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      bp_vld = 1; bp_fp = (i == 0); bp_bit = w[31-i];
      if (i == 0) begin half_pin = pin; cfg_half_wr = wr_now; cfg_half = wr_v; end
      else cfg_half_wr = 0;
    end
    @(negedge clk); bp_vld = 0; bp_fp = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic loose_bits(input int n, input logic with_fp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bp_vld = 1; bp_fp = with_fp && (i == 0); bp_bit = i[0];
    end
    @(negedge clk); bp_vld = 0; bp_fp = 0;
  endtask

  task automatic cfg_write(input logic v);
    @(negedge clk); cfg_half_wr = 1; cfg_half = v;
    @(negedge clk); cfg_half_wr = 0;
  endtask

  task automatic pull(input logic h, input logic [7:0] b1, b2, input logic [1:0] d,
                      input string tag);
    @(negedge clk);
    total++;
    if ({ln_valid, ln_half, ln_b1, ln_b2, ln_d} !== {1'b1, h, b1, b2, d}) begin
      bad++;
      $display("FAIL %s: actual=%b/%b %h %h %b expected=1/%b %h %h %b", tag,
               ln_valid, ln_half, ln_b1, ln_b2, ln_d, h, b1, b2, d);
    end
    ln_ready = 1;
    @(negedge clk);
    ln_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (ln_valid !== 1'b0) begin
      bad++; $display("FAIL R1 valid in reset: actual=%b expected=0", ln_valid);
    end
    rst_n = 1;
    @(negedge clk);
    total++;
    if ({ln_valid, ln_half, ln_b1, ln_b2, ln_d} !== {2'b10, 8'hFF, 8'hFF, 2'b11}) begin
      bad++; $display("FAIL R1 first record: actual=%b%b %h %h %b expected=10 ff ff 11",
                      ln_valid, ln_half, ln_b1, ln_b2, ln_d);
    end

    // R4 / R6: selector 0, formatter active -> D idle
    send_frame(8'hA5, 8'h3C, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0);
    pull(0, 8'hFF, 8'hFF, 2'b11, "R6 idle half0");
    pull(1, 8'hFF, 8'hFF, 2'b11, "R6 idle half1");
    pull(0, 8'h11, 8'h22, 2'b11, "R4 data half0");

    // R3 / R7 / R9: pin edge to 1, bypass
    cfg_hdlc_tx_en = 0; cfg_hdlc_rx_en = 0;
    send_frame(8'hA6, 8'h00, 8'h12, 8'h34, 1'b1, 1'b0, 1'b0);
    pull(1, 8'hFF, 8'hFF, 2'b11, "R3 idle before data");
    pull(0, 8'hFF, 8'hFF, 2'b11, "R6 idle half0");
    pull(1, 8'h12, 8'h34, 2'b10, "R3 R9 bypass half1");

    // R8 / R7: pin held, network write selects 0
    cfg_hdlc_tx_en = 1;
    cfg_write(0);
    send_frame(8'h0F, 8'h00, 8'h33, 8'h35, 1'b1, 1'b0, 1'b0);
    pull(0, 8'hFF, 8'hFF, 2'b11, "R7 idle half0");
    pull(1, 8'hFF, 8'hFF, 2'b11, "R7 idle half1");
    pull(0, 8'h33, 8'h35, 2'b11, "R8 write sets half0");

    // R8: terminal mode ignores write
    term_mode = 1;
    cfg_write(1);
    send_frame(8'h01, 8'h00, 8'h44, 8'h45, 1'b1, 1'b0, 1'b0);
    pull(1, 8'hFF, 8'hFF, 2'b11, "R8 half1 stays idle");
    pull(0, 8'h44, 8'h45, 2'b11, "R8 terminal write ignored");
    term_mode = 0;

    // R10: D-in-B1 overrides bypass
    cfg_dinb = 1; cfg_hdlc_tx_en = 0; cfg_hdlc_rx_en = 0;
    send_frame(8'h5A, 8'h00, 8'h77, 8'h88, 1'b1, 1'b0, 1'b0);
    pull(1, 8'hFF, 8'hFF, 2'b11, "R10 half1 idle");
    pull(0, 8'h5A, 8'h88, 2'b11, "R10 D in B1");
    cfg_dinb = 0; cfg_hdlc_tx_en = 1; cfg_hdlc_rx_en = 1;

    // R8 / R7: pin edge and write in the same cycle, pin wins
    send_frame(8'h02, 8'h00, 8'h66, 8'h67, 1'b0, 1'b1, 1'b1);
    pull(1, 8'hFF, 8'hFF, 2'b11, "R8 half1 idle");
    pull(0, 8'h66, 8'h67, 2'b11, "R8 pin beats write");

    // R2: restart mid-frame, trailing bits ignored
    loose_bits(10, 1'b1);
    send_frame(8'h03, 8'h00, 8'h99, 8'h9A, 1'b0, 1'b0, 1'b0);
    loose_bits(8, 1'b0);
    repeat (2) @(negedge clk);
    pull(1, 8'hFF, 8'hFF, 2'b11, "R2 half1 idle");
    pull(0, 8'h99, 8'h9A, 2'b11, "R2 restart and ignore");

    // R11: later frame replaces pending one
    send_frame(8'h04, 8'h00, 8'hA1, 8'hB1, 1'b0, 1'b0, 1'b0);
    send_frame(8'h05, 8'h00, 8'hA2, 8'hB2, 1'b0, 1'b0, 1'b0);
    pull(1, 8'hFF, 8'hFF, 2'b11, "R11 half1 idle");
    pull(0, 8'hA2, 8'hB2, 2'b11, "R11 latest pending wins");

    // R11 / R5: streaming with irregular ready, judged by the model
    fork
      begin
        for (int f = 0; f < 8; f++) begin
          cfg_dinb = (f % 3 == 2);
          cfg_hdlc_tx_en = (f % 2 == 0);
          cfg_hdlc_rx_en = (f % 4 == 0);
          send_frame(8'(f * 17 + 1), 8'hC0, 8'(f * 29 + 3), 8'(f * 7 + 5),
                     (f % 3 == 1), (f == 4), 1'b1);
        end
      end
      begin
        for (int k = 0; k < 320; k++) begin
          @(negedge clk);
          ln_ready = ((k % 5) != 1) && ((k % 7) != 3);
        end
        @(negedge clk);
        ln_ready = 0;
      end
    join
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule